// File: doc/BRIEF.md
# Sequential shift-add multiplier

This block multiplies two unsigned 8-bit operands. It works through one multiplier bit per clock cycle and returns a 16-bit product. A load strobe captures both operands and clears the accumulator. The multiplicand is zero-extended into a 16-bit register that shifts left by one each cycle. The multiplier sits in an 8-bit register that shifts right by one each cycle. The vacated bit of each register is filled with zero.

Each cycle the lowest bit of the multiplier register is examined. When that bit is 1, a full 16-bit adder adds the shifted multiplicand into the accumulator; when it is 0, the accumulator holds its value. A small iteration counter stops the shifting after eight steps and raises the done flag. The product then stays frozen until the next load or reset.

A load may arrive at any time. It discards any operation in progress and starts a new one, so results can be issued back to back.

Top module: `seq_shift_mul`

## Requirements
- R1: A synchronous reset drives the product output to 0 and done to 0. Done then stays 0 and the product stays 0 until a load has been seen.
- R2: At every rising edge where load is 1, the operands are captured and the product is cleared to 0. Done is 0 in the cycle after such an edge.
- R3: Load takes priority over computation. A load during a running operation, or while done is high, starts a new multiplication with the newly presented operands.
- R4: When done rises, the product equals the unsigned product of the captured operands. This includes 255 × 255 = 65025 and a product of 0 whenever either operand is 0.
- R5: Done rises exactly 8 rising edges after the last edge with load high, and is 0 before that.
- R6: While done is high and neither load nor reset is applied, the product and done hold their values.
- R7: After k compute edges (0 ≤ k ≤ 8), the product equals the multiplicand times the value of the multiplier's k lowest bits. Bits are examined from least significant upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture operands and clear the product |
| mcand | input | 8 | Multiplicand operand |
| mplier | input | 8 | Multiplier operand |
| prod | output | 16 | Accumulated product |
| done | output | 1 | Eight iterations completed, product final |

## Verification
A load can coincide with the compute step, both in the middle of an operation and in the cycle where done is already high. Load must win in either case. The bench provokes this in two ways. It issues a new load a few cycles into a running operation. It also drives the next load in the very cycle done is first visible. The scoreboard then expects only the second result, and expects it to follow the usual 8-cycle latency counted from the new load. The per-cycle partial-product check (R7) also confirms that no step of the old operation leaked into the new accumulator.

// File: rtl/seq_shift_mul.sv
module seq_shift_mul #(
  parameter int OPW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OPW-1:0]   mcand,
  input  logic [OPW-1:0]   mplier,
  output logic [2*OPW-1:0] prod,
  output logic             done
);
  localparam int PW = 2 * OPW;
  localparam int CW = $clog2(OPW) + 1;
  localparam logic [CW-1:0] LAST = CW'(OPW);

  logic [PW-1:0]  mc_q;
  logic [OPW-1:0] mp_q;
  logic [PW-1:0]  acc_q;
  logic [CW-1:0]  cnt_q;
  logic           armed_q;
  logic           step;
  logic [PW-1:0]  sum;

  assign step = armed_q && (cnt_q != LAST);
  assign sum  = acc_q + mc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q    <= '0;
      mp_q    <= '0;
      acc_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      mc_q    <= {{(PW-OPW){1'b0}}, mcand};
      mp_q    <= mplier;
      acc_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (step) begin
      mc_q  <= {mc_q[PW-2:0], 1'b0};
      mp_q  <= {1'b0, mp_q[OPW-1:1]};
      cnt_q <= cnt_q + 1'b1;
      if (mp_q[0]) acc_q <= sum;
    end
  end

  assign prod = acc_q;
  assign done = armed_q && (cnt_q == LAST);
endmodule

// File: rtl/seq_shift_mul_chk.sv
module seq_shift_mul_chk #(
  parameter int OPW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic [2*OPW-1:0] prod,
  input logic             done
);
  logic [4:0] since_q;
  logic       seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (load) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != 5'd31) begin
      since_q <= since_q + 1'b1;
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (prod == '0) && !done);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst) !seen_q |-> !done && (prod == '0));
  a_r2_load_clears: assert property (@(posedge clk) disable iff (rst) load |=> (prod == '0) && !done);
  a_r5_not_early: assert property (@(posedge clk) disable iff (rst) (since_q < 5'(OPW)) |-> !done);
  a_r5_on_time: assert property (@(posedge clk) disable iff (rst) (seen_q && since_q >= 5'(OPW)) |-> done);
  a_r6_hold: assert property (@(posedge clk) disable iff (rst) (done && !load) |=> $stable(prod) && done);
  a_r7_grows: assert property (@(posedge clk) disable iff (rst) (!load && !done) |=> prod >= $past(prod));
endmodule

bind seq_shift_mul seq_shift_mul_chk #(.OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .load(load), .prod(prod), .done(done)
);

// File: tb/sim_seq_shift_mul.sv
module sim_seq_shift_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [7:0]  mcand = '0;
  logic [7:0]  mplier = '0;
  logic [15:0] prod;
  logic        done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;
  logic [15:0] expq[$];

  always #4 clk = ~clk;

  seq_shift_mul u0 (.clk(clk), .rst(rst), .load(load), .mcand(mcand),
                    .mplier(mplier), .prod(prod), .done(done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver: called at a negedge, returns at a negedge
  task automatic op(input logic [7:0] a, input logic [7:0] b, input int hold, input bit complete);
    mcand = a; mplier = b; load = 1'b1;
    if (complete) expq.push_back(16'(a) * 16'(b));
    repeat (hold) @(negedge clk);
    load = 1'b0;
    if (complete) repeat (8) @(negedge clk);
  endtask

  // monitor
  bit        m_armed = 0;
  int        m_since = 0;
  logic [7:0] m_a = '0, m_b = '0;
  bit        m_prev_done = 0;

  always @(posedge clk) begin
    bit e_rst, e_load;
    logic [7:0] ea, eb;
    logic [15:0] want;
    e_rst = rst; e_load = load; ea = mcand; eb = mplier;
    cycles++;
    #2;
    if (e_rst) begin
      m_armed = 0; m_since = 0;
      chk(prod == 0 && done == 0, "R1", {prod, 15'b0, done}, 0);
    end else if (e_load) begin
      m_armed = 1; m_since = 0; m_a = ea; m_b = eb;
      chk(prod == 0 && done == 0, "R2", {prod, 15'b0, done}, 0);
    end else if (!m_armed) begin
      chk(prod == 0 && done == 0, "R1", {prod, 15'b0, done}, 0);
    end else if (m_since < 8) begin
      m_since++;
      want = 16'(m_a) * 16'(m_b & 8'((9'd1 << m_since) - 9'd1));
      chk(prod == want, "R7", prod, want);
      chk(done == (m_since == 8), "R5", done, m_since == 8);
      if (m_since == 8 && done) begin
        if (expq.size() == 0) chk(0, "R3", prod, 0);
        else begin
          want = expq.pop_front();
          chk(prod == want, "R4", prod, want);
        end
      end
    end else begin
      want = 16'(m_a) * 16'(m_b);
      chk(prod == want && done == 1, "R6", {prod, 15'b0, done}, {want, 16'd1});
    end
    m_prev_done = done;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);        // R1: idle without load
    // R4 corners
    op(8'd255, 8'd255, 1, 1);
    op(8'd0, 8'd77, 1, 1);
    op(8'd77, 8'd0, 1, 1);
    op(8'd0, 8'd0, 1, 1);
    op(8'd1, 8'd1, 1, 1);
    op(8'd128, 8'd2, 1, 1);
    op(8'd255, 8'd1, 1, 1);
    op(8'd1, 8'd255, 1, 1);
    op(8'd170, 8'd85, 1, 1);
    repeat (6) @(negedge clk);         // R6 hold window
    // R3 abort mid-run
    op(8'd200, 8'd199, 1, 0);
    repeat (3) @(negedge clk);
    op(8'd36, 8'd66, 1, 1);
    // R2 load held several cycles, last operands win
    mcand = 8'd9; mplier = 8'd9; load = 1'b1;
    @(negedge clk);
    op(8'd100, 8'd200, 3, 1);
    // R1 reset during a run
    op(8'd123, 8'd45, 1, 0);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    // random back-to-back (R3 load on the done cycle)
    for (int i = 0; i < 40; i++)
      op(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 1, 1);
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R4", expq.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait (cycles > 100000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule